// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block keeps a small ring of in-flight stores and answers, for each load, which of the load's eight byte lanes must be taken from an older store instead of memory. A load is presented in one cycle. One cycle later it gets an early lane mask built from virtual-address hits. One cycle after that it gets the final lane mask and the forwarded bytes, built from physical-address hits.

The final answer also carries two hazard flags. The first is a replay flag, with the slot number of the store whose bytes are not yet present. The second is a flush request, raised when the virtual and physical comparisons disagree about which stores hit.

Stores enter in three separate steps: allocation, which writes the addresses; a byte-mask write, which takes two cycles to land; and a data write. They leave in order through dequeue. The load supplies its own ordering as one bit per slot, marking the stores older than itself, so the lookup never decodes a queue pointer. Address widths are package constants. The slot count `N` must be a power of two.

Top module: `stlf_lookup`

## Requirements
- R1: While `ld_valid` is low in the query cycle, every stage-1 output (one cycle later) and every stage-2 output (two cycles later) is zero. The same holds out of reset.
- R2: A slot takes part in a lookup only if it is live, its bit in `ld_older` is set, its address bits from bit 3 upward equal the load's, and its byte mask shares at least one set bit with `ld_mask`.
- R3: For each lane set in `ld_mask`, the source is the participating slot that covers that lane and is youngest in ring order. Ring order starts at the oldest live slot, so it wraps past slot N-1 to slot 0.
- R4: `s1_fwd_mask` and `s1_data_inv` appear one cycle after the query and are computed from virtual-address participation.
- R5: `s2_fwd_mask` and `s2_fwd_data` appear two cycles after the query and are computed from physical-address participation. Lane j of the data is bits 8j+7..8j, taken from the same bits of the source store's data. Lanes that are not forwarded read zero.
- R6: A lane is forwarded only if its source slot holds data. If any lane's source lacks data, the data-invalid flag of that stage is set. `s2_inv_idx` names the source slot of the lowest such lane. There is no fallback to an older store.
- R7: `s2_match_inv` is set when the set of participating slots found by virtual address differs from the set found by physical address.
- R8: A byte-mask write issued in cycle t is visible to a query presented in cycle t+2 and later, and is not visible to a query presented in cycle t+1.
- R9: Allocation writes the slot shown on `st_alloc_idx`, clears that slot's mask and data-present bit, and advances the index modulo N. Dequeue frees the oldest live slot.
- R10: `flush` empties every slot and returns `st_alloc_idx` and the oldest pointer to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the store ring |
| st_alloc_valid | input | 1 | Allocate a slot at the tail |
| st_alloc_va | input | STLF_VA_W | Virtual address of the new store |
| st_alloc_pa | input | STLF_PA_W | Physical address of the new store |
| st_alloc_idx | output | log2(N) | Slot the next allocation writes |
| st_mask_valid | input | 1 | Byte-mask write request |
| st_mask_idx | input | log2(N) | Slot of the mask write |
| st_mask | input | 8 | Byte mask of the store |
| st_data_valid | input | 1 | Data write request |
| st_data_idx | input | log2(N) | Slot of the data write |
| st_data | input | 64 | Store data, byte j in bits 8j+7..8j |
| st_deq | input | 1 | Free the oldest slot |
| ld_valid | input | 1 | Load query present |
| ld_va | input | STLF_VA_W | Load virtual address |
| ld_pa | input | STLF_PA_W | Load physical address |
| ld_mask | input | 8 | Load byte lanes |
| ld_older | input | N | One bit per slot, set for stores older than the load |
| s1_fwd_mask | output | 8 | Early forward lanes |
| s1_data_inv | output | 1 | Early data-not-present flag |
| s2_fwd_mask | output | 8 | Final forward lanes |
| s2_fwd_data | output | 64 | Forwarded bytes |
| s2_data_inv | output | 1 | Final data-not-present flag |
| s2_inv_idx | output | log2(N) | Slot blocking the load |
| s2_match_inv | output | 1 | Virtual and physical hit sets disagree |

## Verification
The bench builds the block with N=4, so the allocation index wraps to slot 0 after only four stores. One dequeue then places a live slot 0 as the youngest entry behind slots 1 to 3, which exposes any selection that follows plain slot numbers instead of ring order. The small ring also lets one store setup cover overlapping masks, partial overlap, missing data, and a store whose virtual and physical addresses lie in different doublewords. That last case makes the early and final answers differ and triggers the flush request.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
    parameter int STLF_VA_W = 24;
    parameter int STLF_PA_W = 20;
    localparam int LANES     = 8;
    localparam int BYTE_W    = 8;
    localparam int DWORD_LSB = 3;

    typedef logic [LANES-1:0]        lane_mask_t;
    typedef logic [LANES*BYTE_W-1:0] dword_t;

    typedef struct packed {
        logic                 live;
        logic [STLF_VA_W-1:0] va;
        logic [STLF_PA_W-1:0] pa;
        lane_mask_t           mask;
        logic                 has_data;
        dword_t               data;
    } st_entry_t;

    function automatic logic [BYTE_W-1:0] lane_byte(dword_t d, int lane);
        return d[lane*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/stlf_store_buf.sv
module stlf_store_buf
    import stlf_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 alloc_valid,
    input  logic [STLF_VA_W-1:0] alloc_va,
    input  logic [STLF_PA_W-1:0] alloc_pa,
    output logic [IDX_W-1:0]     alloc_idx,
    input  logic                 mask_valid,
    input  logic [IDX_W-1:0]     mask_idx,
    input  lane_mask_t           mask_val,
    input  logic                 data_valid,
    input  logic [IDX_W-1:0]     data_idx,
    input  dword_t               data_val,
    input  logic                 deq,
    output st_entry_t            ent_o [N],
    output logic [IDX_W-1:0]     head_o
);
    st_entry_t        ent_q [N];
    logic [IDX_W-1:0] head_q, tail_q;

    // second step of the mask write: the request is held here for one cycle
    logic             mwr_v_q;
    logic [IDX_W-1:0] mwr_idx_q;
    lane_mask_t       mwr_mask_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q     <= '0;
            tail_q     <= '0;
            mwr_v_q    <= 1'b0;
            mwr_idx_q  <= '0;
            mwr_mask_q <= '0;
        end else begin
            mwr_v_q    <= mask_valid;
            mwr_idx_q  <= mask_idx;
            mwr_mask_q <= mask_val;
            if (alloc_valid) tail_q <= tail_q + 1'b1;
            if (deq)         head_q <= head_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || flush) begin
                ent_q[i] <= '0;
            end else if (alloc_valid && tail_q == IDX_W'(i)) begin
                ent_q[i].live     <= 1'b1;
                ent_q[i].va       <= alloc_va;
                ent_q[i].pa       <= alloc_pa;
                ent_q[i].mask     <= '0;
                ent_q[i].has_data <= 1'b0;
            end else begin
                if (mwr_v_q && mwr_idx_q == IDX_W'(i))
                    ent_q[i].mask <= mwr_mask_q;
                if (data_valid && data_idx == IDX_W'(i)) begin
                    ent_q[i].has_data <= 1'b1;
                    ent_q[i].data     <= data_val;
                end
                if (deq && head_q == IDX_W'(i))
                    ent_q[i].live <= 1'b0;
            end
        end
    end

    assign ent_o     = ent_q;
    assign head_o    = head_q;
    assign alloc_idx = tail_q;
endmodule

// File: rtl/stlf_addr_match.sv
module stlf_addr_match
    import stlf_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 24
) (
    input  logic [AW-1:0]             q_addr,
    input  lane_mask_t                q_mask,
    input  logic [N-1:0]              older,
    input  logic [N-1:0]              live,
    input  logic [N-1:0][AW-1:0]      addr,
    input  logic [N-1:0][LANES-1:0]   mask,
    output logic [N-1:0]              hit,
    output logic [LANES-1:0][N-1:0]   cand
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign hit[i] = live[i] & older[i]
                      & (addr[i][AW-1:DWORD_LSB] == q_addr[AW-1:DWORD_LSB])
                      & (|(mask[i] & q_mask));
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign cand[j][i] = hit[i] & mask[i][j] & q_mask[j];
        end
    end
endmodule

// File: rtl/stlf_youngest.sv
module stlf_youngest #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] sel
);
    // walk from the oldest slot towards the tail; the last hit is the youngest
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < N; k++) begin
            logic [IDX_W-1:0] idx;
            idx = head + IDX_W'(k);
            if (cand[idx]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
    end
endmodule

// File: rtl/stlf_lookup.sv
module stlf_lookup
    import stlf_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 st_alloc_valid,
    input  logic [STLF_VA_W-1:0] st_alloc_va,
    input  logic [STLF_PA_W-1:0] st_alloc_pa,
    output logic [IDX_W-1:0]     st_alloc_idx,
    input  logic                 st_mask_valid,
    input  logic [IDX_W-1:0]     st_mask_idx,
    input  logic [LANES-1:0]     st_mask,
    input  logic                 st_data_valid,
    input  logic [IDX_W-1:0]     st_data_idx,
    input  logic [63:0]          st_data,
    input  logic                 st_deq,
    input  logic                 ld_valid,
    input  logic [STLF_VA_W-1:0] ld_va,
    input  logic [STLF_PA_W-1:0] ld_pa,
    input  logic [LANES-1:0]     ld_mask,
    input  logic [N-1:0]         ld_older,
    output logic [LANES-1:0]     s1_fwd_mask,
    output logic                 s1_data_inv,
    output logic [LANES-1:0]     s2_fwd_mask,
    output logic [63:0]          s2_fwd_data,
    output logic                 s2_data_inv,
    output logic [IDX_W-1:0]     s2_inv_idx,
    output logic                 s2_match_inv
);
    st_entry_t        ent [N];
    logic [IDX_W-1:0] head;

    stlf_store_buf #(.N(N)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .alloc_valid(st_alloc_valid),
        .alloc_va   (st_alloc_va),
        .alloc_pa   (st_alloc_pa),
        .alloc_idx  (st_alloc_idx),
        .mask_valid (st_mask_valid),
        .mask_idx   (st_mask_idx),
        .mask_val   (st_mask),
        .data_valid (st_data_valid),
        .data_idx   (st_data_idx),
        .data_val   (st_data),
        .deq        (st_deq),
        .ent_o      (ent),
        .head_o     (head)
    );

    logic [N-1:0]                live_v, dv_v;
    logic [N-1:0][STLF_VA_W-1:0] va_v;
    logic [N-1:0][STLF_PA_W-1:0] pa_v;
    logic [N-1:0][LANES-1:0]     msk_v;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            live_v[i] = ent[i].live;
            dv_v[i]   = ent[i].has_data;
            va_v[i]   = ent[i].va;
            pa_v[i]   = ent[i].pa;
            msk_v[i]  = ent[i].mask;
        end
    end

    // ---------------- stage 0: virtual-address compare ----------------
    logic [N-1:0]            va_hit0;
    logic [LANES-1:0][N-1:0] va_cand0;

    stlf_addr_match #(.N(N), .AW(STLF_VA_W)) u_vmatch (
        .q_addr(ld_va),
        .q_mask(ld_mask),
        .older (ld_older),
        .live  (live_v),
        .addr  (va_v),
        .mask  (msk_v),
        .hit   (va_hit0),
        .cand  (va_cand0)
    );

    logic                    s1_v;
    logic [STLF_PA_W-1:0]    s1_pa;
    lane_mask_t              s1_mask;
    logic [N-1:0]            s1_older;
    logic [N-1:0]            s1_va_hit;
    logic [LANES-1:0][N-1:0] s1_va_cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v       <= 1'b0;
            s1_pa      <= '0;
            s1_mask    <= '0;
            s1_older   <= '0;
            s1_va_hit  <= '0;
            s1_va_cand <= '0;
        end else begin
            s1_v       <= ld_valid;
            s1_pa      <= ld_pa;
            s1_mask    <= ld_mask;
            s1_older   <= ld_older;
            s1_va_hit  <= va_hit0;
            s1_va_cand <= va_cand0;
        end
    end

    // ---------------- stage 1: physical compare and lane selection -----
    logic [N-1:0]            pa_hit;
    logic [LANES-1:0][N-1:0] pa_cand;

    stlf_addr_match #(.N(N), .AW(STLF_PA_W)) u_pmatch (
        .q_addr(s1_pa),
        .q_mask(s1_mask),
        .older (s1_older),
        .live  (live_v),
        .addr  (pa_v),
        .mask  (msk_v),
        .hit   (pa_hit),
        .cand  (pa_cand)
    );

    logic [LANES-1:0]             f_found, f_lane, f_block;
    logic [LANES-1:0]             p_found, p_lane, p_block;
    logic [IDX_W-1:0]             f_sel [LANES];
    logic [IDX_W-1:0]             p_sel [LANES];
    logic [LANES-1:0][BYTE_W-1:0] p_byte;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        stlf_youngest #(.N(N)) u_fast (
            .cand (s1_va_cand[j]),
            .head (head),
            .found(f_found[j]),
            .sel  (f_sel[j])
        );
        stlf_youngest #(.N(N)) u_final (
            .cand (pa_cand[j]),
            .head (head),
            .found(p_found[j]),
            .sel  (p_sel[j])
        );
        assign f_lane[j]  = f_found[j] &  dv_v[f_sel[j]];
        assign f_block[j] = f_found[j] & ~dv_v[f_sel[j]];
        assign p_lane[j]  = p_found[j] &  dv_v[p_sel[j]];
        assign p_block[j] = p_found[j] & ~dv_v[p_sel[j]];
        assign p_byte[j]  = p_lane[j] ? lane_byte(ent[p_sel[j]].data, j) : '0;
    end

    // blocking slot: that of the lowest lane whose source has no data
    logic [IDX_W-1:0] blk_idx;
    always_comb begin
        blk_idx = '0;
        for (int j = LANES - 1; j >= 0; j--) begin
            if (p_block[j]) blk_idx = p_sel[j];
        end
    end

    assign s1_fwd_mask = s1_v ? f_lane : '0;
    assign s1_data_inv = s1_v & (|f_block);

    // ---------------- stage 2: registered final answer ----------------
    always_ff @(posedge clk) begin
        if (rst || !s1_v) begin
            s2_fwd_mask  <= '0;
            s2_fwd_data  <= '0;
            s2_data_inv  <= 1'b0;
            s2_inv_idx   <= '0;
            s2_match_inv <= 1'b0;
        end else begin
            s2_fwd_mask  <= p_lane;
            s2_fwd_data  <= p_byte;
            s2_data_inv  <= |p_block;
            s2_inv_idx   <= blk_idx;
            s2_match_inv <= (s1_va_hit != pa_hit);
        end
    end
endmodule

// File: rtl/stlf_lookup_chk.sv
module stlf_lookup_chk #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             st_alloc_valid,
    input logic [IDX_W-1:0] st_alloc_idx,
    input logic             ld_valid,
    input logic [7:0]       ld_mask,
    input logic [7:0]       s1_fwd_mask,
    input logic             s1_data_inv,
    input logic [7:0]       s2_fwd_mask,
    input logic             s2_data_inv,
    input logic             s2_match_inv
);
    assert_s1_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_valid) |-> (s1_fwd_mask == '0 && !s1_data_inv));

    assert_s2_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_valid, 2) |-> (s2_fwd_mask == '0 && !s2_data_inv && !s2_match_inv));

    assert_lanes_in_load_R5: assert property (@(posedge clk) disable iff (rst)
        (s2_fwd_mask & ~$past(ld_mask, 2)) == '0);

    assert_alloc_step_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(st_alloc_valid) && !$past(flush) && !$past(rst))
            |-> st_alloc_idx == IDX_W'($past(st_alloc_idx) + 1'b1));

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> st_alloc_idx == '0);
endmodule

bind stlf_lookup stlf_lookup_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .st_alloc_valid(st_alloc_valid),
    .st_alloc_idx  (st_alloc_idx),
    .ld_valid      (ld_valid),
    .ld_mask       (ld_mask),
    .s1_fwd_mask   (s1_fwd_mask),
    .s1_data_inv   (s1_data_inv),
    .s2_fwd_mask   (s2_fwd_mask),
    .s2_data_inv   (s2_data_inv),
    .s2_match_inv  (s2_match_inv)
);

// File: tb/tb_stlf_lookup.sv
module tb_stlf_lookup;
    import stlf_pkg::*;

    localparam int N = 4;
    localparam int IW = 2;

    logic                 clk = 1'b0;
    logic                 rst, flush;
    logic                 st_alloc_valid;
    logic [STLF_VA_W-1:0] st_alloc_va;
    logic [STLF_PA_W-1:0] st_alloc_pa;
    logic [IW-1:0]        st_alloc_idx;
    logic                 st_mask_valid;
    logic [IW-1:0]        st_mask_idx;
    logic [7:0]           st_mask;
    logic                 st_data_valid;
    logic [IW-1:0]        st_data_idx;
    logic [63:0]          st_data;
    logic                 st_deq;
    logic                 ld_valid;
    logic [STLF_VA_W-1:0] ld_va;
    logic [STLF_PA_W-1:0] ld_pa;
    logic [7:0]           ld_mask;
    logic [N-1:0]         ld_older;
    logic [7:0]           s1_fwd_mask, s2_fwd_mask;
    logic                 s1_data_inv, s2_data_inv, s2_match_inv;
    logic [63:0]          s2_fwd_data;
    logic [IW-1:0]        s2_inv_idx;

    always #4 clk = ~clk;

    stlf_lookup #(.N(N)) dut (.*);

    int n_chk = 0;
    int n_err = 0;

    // reference copy of the ring, driven from the bench's own stimulus
    logic        m_live [N];
    logic [19:0] m_pa   [N];
    logic [7:0]  m_mask [N];
    logic        m_dv   [N];
    logic [63:0] m_data [N];
    int          m_head = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pattern(int slot);
        logic [63:0] d;
        for (int j = 0; j < 8; j++) d[j*8 +: 8] = {4'(slot + 1), 4'(j)};
        return d;
    endfunction

    // expected bytes: scan the ring oldest to youngest, the last covering store wins
    function automatic logic [63:0] ref_data(logic [19:0] pa, logic [7:0] m, logic [N-1:0] old);
        logic [63:0] d;
        d = '0;
        for (int j = 0; j < 8; j++) begin
            int src;
            src = -1;
            for (int k = 0; k < N; k++) begin
                int s;
                s = (m_head + k) % N;
                if (m_live[s] && old[s] && m_pa[s][19:3] == pa[19:3] && (m_mask[s] & m) != 0
                    && m_mask[s][j] && m[j]) src = s;
            end
            if (src >= 0 && m_dv[src]) d[j*8 +: 8] = m_data[src][j*8 +: 8];
        end
        return d;
    endfunction

    task automatic idle();
        st_alloc_valid = 0; st_mask_valid = 0; st_data_valid = 0; st_deq = 0;
        ld_valid = 0; flush = 0;
    endtask

    task automatic do_alloc(input logic [23:0] va, input logic [19:0] pa);
        @(negedge clk);
        m_live[st_alloc_idx] = 1; m_pa[st_alloc_idx] = pa;
        m_mask[st_alloc_idx] = 0; m_dv[st_alloc_idx] = 0;
        st_alloc_valid = 1; st_alloc_va = va; st_alloc_pa = pa;
        @(negedge clk);
        st_alloc_valid = 0;
    endtask

    task automatic do_mask(input int slot, input logic [7:0] m);
        @(negedge clk);
        st_mask_valid = 1; st_mask_idx = IW'(slot); st_mask = m; m_mask[slot] = m;
        @(negedge clk);
        st_mask_valid = 0;
        @(negedge clk);
    endtask

    task automatic do_data(input int slot);
        @(negedge clk);
        st_data_valid = 1; st_data_idx = IW'(slot); st_data = pattern(slot);
        m_dv[slot] = 1; m_data[slot] = pattern(slot);
        @(negedge clk);
        st_data_valid = 0;
    endtask

    logic [7:0]  r1m, r2m;
    logic        r1d, r2d, r2x;
    logic [63:0] r2dat;
    logic [1:0]  r2i;

    task automatic query(input logic v, input logic [23:0] va, input logic [19:0] pa,
                         input logic [7:0] m, input logic [N-1:0] old);
        @(negedge clk);
        ld_valid = v; ld_va = va; ld_pa = pa; ld_mask = m; ld_older = old;
        @(negedge clk);
        ld_valid = 0;
        r1m = s1_fwd_mask; r1d = s1_data_inv;
        @(negedge clk);
        r2m = s2_fwd_mask; r2d = s2_data_inv; r2i = s2_inv_idx; r2x = s2_match_inv; r2dat = s2_fwd_data;
    endtask

    typedef struct packed {
        logic [23:0] va;
        logic [19:0] pa;
        logic [7:0]  m;
        logic [3:0]  old;
        logic [7:0]  e1m;
        logic        e1d;
        logic [7:0]  e2m;
        logic        e2d;
        logic [1:0]  eidx;
        logic        ex;
    } vec_t;

    // slots: 0 {va/pa 100, 0F, data} 1 {100, 3C, data} 2 {va 108 pa 208, FF, data} 3 {100, C0, no data}
    localparam vec_t TAB [8] = '{
        '{24'h100, 20'h100, 8'hFF, 4'b0001, 8'h0F, 1'b0, 8'h0F, 1'b0, 2'd0, 1'b0},
        '{24'h100, 20'h100, 8'hFF, 4'b0011, 8'h3F, 1'b0, 8'h3F, 1'b0, 2'd0, 1'b0},
        '{24'h100, 20'h100, 8'hFF, 4'b1111, 8'h3F, 1'b1, 8'h3F, 1'b1, 2'd3, 1'b0},
        '{24'h100, 20'h100, 8'h0F, 4'b1111, 8'h0F, 1'b0, 8'h0F, 1'b0, 2'd0, 1'b0},
        '{24'h108, 20'h208, 8'h81, 4'b0111, 8'h81, 1'b0, 8'h81, 1'b0, 2'd0, 1'b0},
        '{24'h108, 20'h100, 8'hFF, 4'b1111, 8'hFF, 1'b0, 8'h3F, 1'b1, 2'd3, 1'b1},
        '{24'h100, 20'h100, 8'hFF, 4'b0000, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0},
        '{24'h100, 20'h100, 8'hFF, 4'b1110, 8'h3C, 1'b1, 8'h3C, 1'b1, 2'd3, 1'b0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 0; m_pa[i] = 0; m_mask[i] = 0; m_dv[i] = 0; m_data[i] = 0;
        end
        idle();
        st_alloc_va = 0; st_alloc_pa = 0; st_mask_idx = 0; st_mask = 0;
        st_data_idx = 0; st_data = 0; ld_va = 0; ld_pa = 0; ld_mask = 0; ld_older = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset s1 mask", 64'(s1_fwd_mask), 64'h0);
        check("R1 reset s2 mask", 64'(s2_fwd_mask), 64'h0);
        check("R9 reset alloc idx", 64'(st_alloc_idx), 64'h0);

        do_alloc(24'h100, 20'h100);
        do_alloc(24'h100, 20'h100);
        do_alloc(24'h108, 20'h208);
        do_alloc(24'h100, 20'h100);
        check("R9 alloc idx wraps", 64'(st_alloc_idx), 64'h0);
        do_mask(0, 8'h0F);
        do_mask(1, 8'h3C);
        do_mask(2, 8'hFF);
        do_mask(3, 8'hC0);
        do_data(0);
        do_data(1);
        do_data(2);
        repeat (2) @(negedge clk);

        // table walk: R2 participation, R3 youngest, R4 early, R5 final, R6 missing data, R7 disagreement
        for (int t = 0; t < 8; t++) begin
            query(1'b1, TAB[t].va, TAB[t].pa, TAB[t].m, TAB[t].old);
            check($sformatf("R4 row%0d s1 mask", t), 64'(r1m), 64'(TAB[t].e1m));
            check($sformatf("R6 row%0d s1 data_inv", t), 64'(r1d), 64'(TAB[t].e1d));
            check($sformatf("R3 row%0d s2 mask", t), 64'(r2m), 64'(TAB[t].e2m));
            check($sformatf("R5 row%0d s2 data", t), r2dat, ref_data(TAB[t].pa, TAB[t].m, TAB[t].old));
            check($sformatf("R6 row%0d s2 data_inv", t), 64'(r2d), 64'(TAB[t].e2d));
            if (TAB[t].e2d) check($sformatf("R6 row%0d inv idx", t), 64'(r2i), 64'(TAB[t].eidx));
            check($sformatf("R7 row%0d match_inv", t), 64'(r2x), 64'(TAB[t].ex));
        end
        // rows 3 and 6 are the R2 cases: no mask overlap with slot 3, empty older vector

        // R6: data arrives for slot 3, the blocked lanes now forward
        do_data(3);
        query(1'b1, 24'h100, 20'h100, 8'hFF, 4'b1111);
        check("R6 lanes after data", 64'(r2m), 64'hFF);
        check("R6 no block after data", 64'(r2d), 64'h0);
        check("R5 data after data", r2dat, ref_data(20'h100, 8'hFF, 4'b1111));

        // R9: dequeue the oldest slot
        @(negedge clk); st_deq = 1;
        @(negedge clk); st_deq = 0; m_live[0] = 0; m_head = 1;
        query(1'b1, 24'h100, 20'h100, 8'hFF, 4'b1111);
        check("R9 dequeued slot gone", 64'(r2m), 64'hFC);

        do_alloc(24'h100, 20'h100);
        check("R9 alloc idx after wrap", 64'(st_alloc_idx), 64'h1);

        // R8: mask write in cycle t, query in cycle t+1 does not see it
        @(negedge clk);
        st_mask_valid = 1; st_mask_idx = 0; st_mask = 8'h0C;
        @(negedge clk);
        st_mask_valid = 0; m_mask[0] = 8'h0C;
        ld_valid = 1; ld_va = 24'h100; ld_pa = 20'h100; ld_mask = 8'hFF; ld_older = 4'b1111;
        @(negedge clk);
        ld_valid = 0;
        check("R8 mask not yet visible", 64'(s1_fwd_mask), 64'hFC);
        check("R8 no early block", 64'(s1_data_inv), 64'h0);
        repeat (2) @(negedge clk);

        // R3: slot 0 is now the youngest, ahead of slot 1 in ring order
        query(1'b1, 24'h100, 20'h100, 8'hFF, 4'b1111);
        check("R8 mask visible later", 64'(r1m), 64'hF0);
        check("R3 wrap s1 block", 64'(r1d), 64'h1);
        check("R3 wrap s2 mask", 64'(r2m), 64'hF0);
        check("R3 wrap s2 block", 64'(r2d), 64'h1);
        check("R3 wrap blocking slot", 64'(r2i), 64'h0);
        check("R5 wrap data", r2dat, ref_data(20'h100, 8'hFF, 4'b1111));

        // R1: a query with valid low yields nothing
        query(1'b0, 24'h100, 20'h100, 8'hFF, 4'b1111);
        check("R1 invalid s1 mask", 64'(r1m), 64'h0);
        check("R1 invalid s2 mask", 64'(r2m), 64'h0);
        check("R1 invalid s2 block", 64'(r2d), 64'h0);

        // R10: flush empties the ring
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        for (int i = 0; i < N; i++) m_live[i] = 0;
        m_head = 0;
        check("R10 alloc idx after flush", 64'(st_alloc_idx), 64'h0);
        query(1'b1, 24'h100, 20'h100, 8'hFF, 4'b1111);
        check("R10 no lanes after flush", 64'(r2m), 64'h0);
        check("R10 no early lanes after flush", 64'(r1m), 64'h0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule